// File: doc/BRIEF.md
# Supply Reset Pulse Generator

This block produces the system reset for a processor. It watches two digital inputs. The first is a supply-good flag that an external voltage comparator drives. The second is an active-low manual-reset request, which may come from a pushbutton or from a logic line. Reset is held for as long as either cause is present. Once both causes have cleared, reset is held for a further fixed stretch, counted in clock cycles. The stretch is derived from a cycles-per-millisecond parameter and a length in milliseconds, with a nominal 200 ms.

The pulse can be retriggered. A supply dip or a manual request that arrives while the stretch is counting reloads the counter. Reset therefore never lasts less than one full stretch after the last cause goes away, and that stretch lies well above the 140 ms minimum. The same width debounces a mechanical switch, because every bounce simply restarts the stretch.

Both inputs pass through a two-flop synchroniser. The block drives two registered reset outputs, one active-low and one active-high, which are always complements of each other.

Top module: `supply_reset_gen`

## Requirements
- R1: While `supply_ok` is 0, `sys_rst` is 1 and `sys_rst_n` is 0 continuously. A fall of `supply_ok` from an idle state shows on the outputs on the 3rd rising clock edge after the input changes.
- R2: Take N = CYCLES_PER_MS × STRETCH_MS, the number of stretch cycles. After the last cause clears, `sys_rst` stays 1 through clock edges 1 to N+2. It falls to 0 on edge N+3, which is made up of 2 synchroniser edges, N stretch edges and 1 output-register edge.
- R3: A supply dip during a running stretch keeps reset asserted without a gap. After the dip ends, the full N+3-edge timing of R2 applies again, counted from the end of the dip.
- R4: Driving `mr_n` to 0 asserts reset. After `mr_n` returns to 1, reset is held according to R2.
- R5: `sys_rst_n` is the exact complement of `sys_rst` on every cycle after the block reset.
- R6: A burst of single-cycle low pulses on `mr_n` produces one continuous reset. That reset releases N+3 edges after the last return to 1, so no separate debounce filter is needed.
- R7: While `rst_n` is 0 at a clock edge, both outputs take their asserted values (`sys_rst`=1) and the counter is set to zero. With both inputs inactive, the first edge at which `rst_n` is 1 counts as edge 1 of the R2 timing.
- R8: While either cause is active, the counter reloads on every cycle. If one cause clears while the other is still active, the release timing counts only from the moment the last cause clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low block reset (power-on) |
| supply_ok | input | 1 | Asynchronous supply-good flag, 1 = supply above threshold |
| mr_n | input | 1 | Asynchronous manual-reset request, 0 = request |
| sys_rst_n | output | 1 | Active-low system reset |
| sys_rst | output | 1 | Active-high system reset, complement of `sys_rst_n` |

## Verification
The bench builds the block with CYCLES_PER_MS = 4 and STRETCH_MS = 5. That gives a 20-cycle stretch and a release exactly 23 edges after the last cause clears. At this scale, every edge of a full stretch can be checked one by one. The bench also fits in restarts in the middle of a stretch, a bouncing switch, overlapping causes and power-on, all within a few hundred cycles. The default parameters keep the 200 ms scale at 50 MHz and change only the counter width and the load value.

// File: rtl/rpg_pkg.sv
// Package: shared constants for the supply reset pulse generator.
// Assumes: cause index 0 is the supply flag, index 1 the manual request.
package rpg_pkg;
    localparam int unsigned CAUSE_SUPPLY = 0;
    localparam int unsigned CAUSE_MANUAL = 1;
    localparam int unsigned NUM_CAUSES   = 2;

    // Width needed to hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((64'(1) << w) <= 64'(max_val)) w = w + 1;
        return w;
    endfunction
endpackage

// File: rtl/rpg_sync.sv
// Module: rpg_sync
// Multi-bit, bit-independent flop-chain synchroniser for asynchronous levels.
// Assumes: each bit is a slow level (no multi-bit coherence required);
// on reset every stage takes RST_VAL, so reset looks like "cause active".
module rpg_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], din};
        end
    end

    assign dout = stg[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("need 2+ stages"); // R2
    end
endmodule

// File: rtl/rpg_stretch.sv
// Module: rpg_stretch
// Retriggerable stretch counter: reloads while a cause is active, counts
// down to zero afterwards; the reset request is high while either holds.
// Assumes: cause is already synchronous to clk.
module rpg_stretch #(
    parameter int unsigned LOAD_CYCLES = 20,
    parameter int unsigned CNT_W       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic req
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOAD_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Reload on any cause, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cause) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Request reset while a cause is active or the stretch is running.
    always_comb begin
        req = cause || (cnt != '0);
    end

    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> (cnt == LOAD)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause && cnt != '0) |=> (cnt < $past(cnt) || cause)); // R2
endmodule

// File: rtl/rpg_drive.sv
// Module: rpg_drive
// Registers the reset request into separate active-high and active-low
// output flops so both outputs leave the block glitch-free.
// Assumes: req is synchronous; block reset forces both outputs asserted.
module rpg_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rst_hi,
    output logic rst_lo_n
);
    // Register both polarities of the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_hi   <= 1'b1;
            rst_lo_n <= 1'b0;
        end else begin
            rst_hi   <= req;
            rst_lo_n <= ~req;
        end
    end

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lo_n != rst_hi); // R5
    AST_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rst_hi); // R2
    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_hi) |-> !$past(req)); // R2
endmodule

// File: rtl/supply_reset_gen.sv
// Module: supply_reset_gen (top)
// System reset generator: holds reset while the supply is bad or manual
// reset is requested, then stretches it for CYCLES_PER_MS*STRETCH_MS cycles.
// Assumes: supply_ok and mr_n are asynchronous levels; rst_n is synchronous.
module supply_reset_gen #(
    parameter int unsigned CYCLES_PER_MS = 50000,
    parameter int unsigned STRETCH_MS    = 200,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mr_n,
    output logic sys_rst_n,
    output logic sys_rst
);
    import rpg_pkg::*;

    localparam int unsigned STRETCH_CYCLES = CYCLES_PER_MS * STRETCH_MS;
    localparam int unsigned CNT_W          = cnt_width(STRETCH_CYCLES);

    logic [NUM_CAUSES-1:0] raw_ok;
    logic [NUM_CAUSES-1:0] sync_ok;
    logic                  cause;
    logic                  req;

    // Gather inputs as "1 = this cause is inactive".
    always_comb begin
        raw_ok[CAUSE_SUPPLY] = supply_ok;
        raw_ok[CAUSE_MANUAL] = mr_n;
    end

    rpg_sync #(
        .WIDTH   (NUM_CAUSES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_ok),
        .dout  (sync_ok)
    );

    // A cause is active when any synchronised input is not ok.
    always_comb begin
        cause = ~&sync_ok;
    end

    rpg_stretch #(
        .LOAD_CYCLES (STRETCH_CYCLES),
        .CNT_W       (CNT_W)
    ) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause),
        .req   (req)
    );

    rpg_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .rst_hi   (sys_rst),
        .rst_lo_n (sys_rst_n)
    );

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> sys_rst); // R1
    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok[CAUSE_SUPPLY] |=> !sys_rst_n); // R1
    AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ok[CAUSE_MANUAL] |=> sys_rst); // R4
endmodule

// File: tb/supply_reset_gen_tb.sv
module supply_reset_gen_tb;
    localparam int unsigned CPM = 4;
    localparam int unsigned SMS = 5;
    localparam int unsigned N   = CPM * SMS;
    localparam int unsigned LAT = N + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic mr_n = 1'b1;
    logic sys_rst_n;
    logic sys_rst;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    supply_reset_gen #(.CYCLES_PER_MS(CPM), .STRETCH_MS(SMS), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n),
        .sys_rst_n(sys_rst_n), .sys_rst(sys_rst)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Called right after the last cause clears (at a negedge).
    task automatic expect_stretch(input string tag);
        int early = -1;
        for (int k = 1; k < int'(LAT); k++) begin
            cyc(1);
            if ((sys_rst !== 1'b1 || sys_rst_n !== 1'b0) && early < 0) early = k;
        end
        chk(early < 0, {tag, " R2 held until N+2"}, early, -1);
        cyc(1);
        chk(sys_rst === 1'b0, {tag, " R2 release at N+3"}, int'(sys_rst), 0);
        chk(sys_rst_n === ~sys_rst, {tag, " R5 complement"}, int'(sys_rst_n), int'(~sys_rst));
    endtask

    task automatic hold_check(input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            if (sys_rst !== 1'b1 || sys_rst_n !== 1'b0) bad++;
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_power_on();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(3);
        chk(sys_rst === 1'b1 && sys_rst_n === 1'b0, "R7 asserted in block reset", int'(sys_rst), 1);
        rst_n = 1'b1;
        expect_stretch("R7 power-on");
    endtask

    task automatic t_supply_low();
        supply_ok = 1'b0;
        cyc(2);
        chk(sys_rst === 1'b0, "R1 not yet asserted after 2 edges", int'(sys_rst), 0);
        cyc(1);
        chk(sys_rst === 1'b1, "R1 asserted on 3rd edge", int'(sys_rst), 1);
        hold_check(40, "R1 held while supply low");
        supply_ok = 1'b1;
        expect_stretch("R2 supply return");
    endtask

    task automatic t_dip_mid();
        supply_ok = 1'b0;
        cyc(6);
        supply_ok = 1'b1;
        hold_check(10, "R3 stretch running");
        supply_ok = 1'b0;
        hold_check(3, "R3 held during dip");
        supply_ok = 1'b1;
        expect_stretch("R3 after dip");
    endtask

    task automatic t_manual();
        mr_n = 1'b0;
        cyc(3);
        chk(sys_rst === 1'b1, "R4 manual asserts", int'(sys_rst), 1);
        hold_check(15, "R4 held while mr_n low");
        mr_n = 1'b1;
        expect_stretch("R4 manual release");
    endtask

    task automatic t_bounce();
        mr_n = 1'b0; cyc(1);
        mr_n = 1'b1; cyc(1);
        mr_n = 1'b0; cyc(1);
        mr_n = 1'b1; cyc(2);
        mr_n = 1'b0; cyc(1);
        mr_n = 1'b1; cyc(3);
        mr_n = 1'b0; cyc(1);
        mr_n = 1'b1;
        expect_stretch("R6 bounce");
    endtask

    task automatic t_overlap();
        mr_n = 1'b0;
        cyc(2);
        supply_ok = 1'b0;
        cyc(5);
        supply_ok = 1'b1;
        hold_check(30, "R8 held while manual still active");
        mr_n = 1'b1;
        expect_stretch("R8 last cause");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(1);
        t_power_on();
        t_supply_low();
        t_dip_mid();
        t_manual();
        t_bounce();
        t_overlap();
        t_power_on();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule